// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block sits beside a 64-bit data bus that is split into eight byte lanes. When the bus carries write data, the block produces one even-parity bit for every lane from that data. When read data arrives, the block compares each lane with the parity bit that came with it. Only lanes selected by their active-low byte enable take part in the comparison.

When an enabled lane fails, the block reports it on a registered active-low error flag. The whole check can be switched off with an active-low check-enable input. The check is done only on a valid read beat: the data-valid strobe is high and the write strobe is low. The flag goes low for one clock, in the cycle after the failing beat. At all other times it is high.

Top module: `lane_parity_unit`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a rising edge, `parErrN` is high after that edge.
- R2: `wrParity[k]` is the XOR of `wrData[8k+7:8k]`. The eight data bits plus the parity bit then hold an even number of ones. The output is combinational and the byte enables have no effect on it.
- R3: A rising edge can sample a valid read beat (`dataValid`=1, `isWrite`=0) with `chkEnN`=0 and at least one failing enabled lane. A lane fails when the XOR of its eight `rdData` bits and `rdParity[k]` is 1. After that edge, `parErrN` is low.
- R4: The low level on `parErrN` lasts exactly one clock when the next sampled beat does not also fail.
- R5: A lane with `byteEnN[k]`=1 never causes an error, whatever its data and parity.
- R6: While `chkEnN`=1, `parErrN` stays high.
- R7: A beat with `isWrite`=1 is never checked, so `parErrN` stays high after it.
- R8: A cycle with `dataValid`=0 is never checked, so `parErrN` stays high after it.
- R9: A valid, enabled read beat in which every lane holds even parity leaves `parErrN` high.
- R10: Lane k is checked against `rdParity[k]` over `rdData[8k+7:8k]`. Lane 0 is the least significant byte and lane 7 is bits 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrData | input | 64 | Write data to protect |
| wrParity | output | 8 | Even-parity bit for each lane of `wrData` |
| rdData | input | 64 | Incoming read data |
| rdParity | input | 8 | Incoming parity bit for each lane of `rdData` |
| byteEnN | input | 8 | Lane enables, active low |
| chkEnN | input | 1 | Parity-check enable, active low |
| isWrite | input | 1 | 1 = write beat, 0 = read beat |
| dataValid | input | 1 | Beat is valid this cycle |
| parErrN | output | 1 | Registered read-parity error flag, active low |

## Verification
The hardest case to reach from the ports is a beat that fails only in a lane that is masked. Beside it sits a beat that has a masked failing lane and an enabled failing lane at once. A mask or lane-order fault shows up only when these two differ. The stimulus therefore flips the parity bit of one lane at a time, all eight in turn, and runs each flip with that lane enabled and again with it disabled. A final case places a failing beat right after another failing beat and right before a clean one, to measure how wide the pulse is.

// File: rtl/lpar_pkg.sv
package lpar_pkg;
  parameter int DATA_W = 64;
  parameter int LANE_W = 8;
  localparam int LANES = DATA_W / LANE_W;

  typedef struct packed {
    logic checkRead;  // valid read beat that must be checked
    logic clearFlag;  // force error flag inactive
  } lparStrobes_t;
endpackage

// File: rtl/lpar_control.sv
module lpar_control
  import lpar_pkg::*;
(
  input  logic         rst,
  input  logic         chkEnN,
  input  logic         isWrite,
  input  logic         dataValid,
  output lparStrobes_t strobes
);
  always_comb begin
    strobes.clearFlag = rst;
    strobes.checkRead = dataValid && !isWrite && !chkEnN;
  end
endmodule

// File: rtl/lpar_datapath.sv
module lpar_datapath
  import lpar_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 8,
  localparam int NL = DW / LW
) (
  input  logic          clk,
  input  lparStrobes_t  strobes,
  input  logic [DW-1:0] wrData,
  output logic [NL-1:0] wrParity,
  input  logic [DW-1:0] rdData,
  input  logic [NL-1:0] rdParity,
  input  logic [NL-1:0] byteEnN,
  output logic          parErrN
);
  logic [NL-1:0] laneFail;

  for (genvar k = 0; k < NL; k++) begin : gLane
    logic rdOdd;
    assign wrParity[k] = ^wrData[k*LW +: LW];
    assign rdOdd       = (^rdData[k*LW +: LW]) ^ rdParity[k];
    assign laneFail[k] = rdOdd && !byteEnN[k];
  end

  always_ff @(posedge clk) begin
    if (strobes.clearFlag) parErrN <= 1'b1;
    else                   parErrN <= !(strobes.checkRead && (|laneFail));
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lpar_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 8,
  localparam int NL = DW / LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] wrData,
  output logic [NL-1:0] wrParity,
  input  logic [DW-1:0] rdData,
  input  logic [NL-1:0] rdParity,
  input  logic [NL-1:0] byteEnN,
  input  logic          chkEnN,
  input  logic          isWrite,
  input  logic          dataValid,
  output logic          parErrN
);
  lparStrobes_t strobes;

  lpar_control u_ctrl (
    .rst(rst), .chkEnN(chkEnN), .isWrite(isWrite),
    .dataValid(dataValid), .strobes(strobes)
  );

  lpar_datapath #(.DW(DW), .LW(LW)) u_dp (
    .clk(clk), .strobes(strobes), .wrData(wrData), .wrParity(wrParity),
    .rdData(rdData), .rdParity(rdParity), .byteEnN(byteEnN),
    .parErrN(parErrN)
  );
endmodule

// File: rtl/lpar_checker.sv
module lpar_checker #(
  parameter int DW = 64,
  parameter int LW = 8,
  localparam int NL = DW / LW
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] wrData,
  input logic [NL-1:0] wrParity,
  input logic [DW-1:0] rdData,
  input logic [NL-1:0] rdParity,
  input logic [NL-1:0] byteEnN,
  input logic          chkEnN,
  input logic          isWrite,
  input logic          dataValid,
  input logic          parErrN
);
  logic anyBad;
  always_comb begin
    anyBad = 1'b0;
    for (int k = 0; k < NL; k++)
      if (!byteEnN[k] && ((^rdData[k*LW +: LW]) != rdParity[k])) anyBad = 1'b1;
  end

  a_r1_reset_high: assert property (@(posedge clk) rst |=> parErrN);

  a_r2_even_write: assert property (@(posedge clk) disable iff (rst)
    (^{wrData, wrParity}) == 1'b0);

  a_r3_flag_low: assert property (@(posedge clk) disable iff (rst)
    (dataValid && !isWrite && !chkEnN && anyBad) |=> !parErrN);

  a_r9_clean_high: assert property (@(posedge clk) disable iff (rst)
    (dataValid && !isWrite && !anyBad) |=> parErrN);

  a_r5_all_masked: assert property (@(posedge clk) disable iff (rst)
    (&byteEnN) |=> parErrN);

  a_r6_check_off: assert property (@(posedge clk) disable iff (rst)
    chkEnN |=> parErrN);

  a_r7_write_ignored: assert property (@(posedge clk) disable iff (rst)
    isWrite |=> parErrN);

  a_r8_idle_ignored: assert property (@(posedge clk) disable iff (rst)
    !dataValid |=> parErrN);
endmodule

bind lane_parity_unit lpar_checker #(.DW(DW), .LW(LW)) u_lpar_checker (
  .clk(clk), .rst(rst), .wrData(wrData), .wrParity(wrParity),
  .rdData(rdData), .rdParity(rdParity), .byteEnN(byteEnN),
  .chkEnN(chkEnN), .isWrite(isWrite), .dataValid(dataValid),
  .parErrN(parErrN)
);

// File: tb/test_lane_parity_unit.sv
`timescale 1ns/1ps
module test_lane_parity_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] wrData = '0;
  logic [7:0]  wrParity;
  logic [63:0] rdData = '0;
  logic [7:0]  rdParity = '0;
  logic [7:0]  byteEnN = 8'hFF;
  logic        chkEnN = 1'b1;
  logic        isWrite = 1'b0;
  logic        dataValid = 1'b0;
  logic        parErrN;

  int vectors = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lane_parity_unit i_lane_parity_unit (
    .clk(clk), .rst(rst), .wrData(wrData), .wrParity(wrParity),
    .rdData(rdData), .rdParity(rdParity), .byteEnN(byteEnN),
    .chkEnN(chkEnN), .isWrite(isWrite), .dataValid(dataValid),
    .parErrN(parErrN)
  );

  function automatic logic [7:0] goodPar(input logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = ^d[k*8 +: 8];
    return p;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one beat at the falling edge; sample the flag just after the next rising edge.
  task automatic beat(input logic [63:0] d, input logic [7:0] p, input logic [7:0] ben,
                      input logic cen, input logic wr, input logic v);
    @(negedge clk);
    rdData = d; rdParity = p; byteEnN = ben; chkEnN = cen; isWrite = wr; dataValid = v;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    beat('0, '0, 8'hFF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testReset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset flag", parErrN, 1);
    // failing beat presented during reset must still give high flag
    beat(64'h1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R1 reset overrides fail", parErrN, 1);
    @(negedge clk); rst = 1'b0;
    idle();
  endtask

  task automatic testWriteParity();
    logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                              64'h0102_0408_1020_4080, 64'hDEAD_BEEF_0137_F00D};
    foreach (pats[i]) begin
      @(negedge clk);
      wrData = pats[i]; byteEnN = (i % 2 == 0) ? 8'hFF : 8'h00;
      #1;
      check("R2 write parity", wrParity, goodPar(pats[i]));
    end
  endtask

  task automatic testCleanRead();
    beat(64'hA5A5_1234_FFFF_0F0F, goodPar(64'hA5A5_1234_FFFF_0F0F), 8'h00, 1'b0, 1'b0, 1'b1);
    check("R9 clean read", parErrN, 1);
  endtask

  task automatic testEachLane();
    logic [63:0] d = 64'h8877_6655_4433_2211;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] bad = goodPar(d) ^ (8'h1 << k);
      beat(d, bad, ~(8'h1 << k), 1'b0, 1'b0, 1'b1);
      check($sformatf("R3 R10 lane %0d enabled fail", k), parErrN, 0);
      beat(d, bad, (8'h1 << k), 1'b0, 1'b0, 1'b1);
      check($sformatf("R5 R10 lane %0d masked fail", k), parErrN, 1);
    end
    // data flip in top lane with its enable asserted
    beat(d ^ 64'h0100_0000_0000_0000, goodPar(d), 8'h7F, 1'b0, 1'b0, 1'b1);
    check("R10 lane 7 data flip", parErrN, 0);
  endtask

  task automatic testGating();
    beat(64'h0, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1);
    check("R6 check disabled", parErrN, 1);
    beat(64'h0, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1);
    check("R7 write beat ignored", parErrN, 1);
    beat(64'h0, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R8 invalid beat ignored", parErrN, 1);
  endtask

  task automatic testPulse();
    beat(64'h0, 8'h10, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R4 first fail low", parErrN, 0);
    beat(64'h0, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1);
    check("R4 back-to-back fail low", parErrN, 0);
    idle();
    check("R4 pulse ends", parErrN, 1);
    idle();
    check("R4 stays high", parErrN, 1);
  endtask

  initial begin
    fork
      begin
        testReset();
        testWriteParity();
        testCleanRead();
        testEachLane();
        testGating();
        testPulse();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule